// File: doc/BRIEF.md
# Memory Barrier Ordering Tracker

This block holds memory operations back behind in-flight memory barriers. It models an instruction buffer of `NSLOT` slots. When an instruction is dispatched into a slot, the tracker decides whether that slot is free to issue as far as memory ordering goes. A memory reference or a barrier that arrives while an older barrier is still uncommitted is linked to that barrier. A slot linked in this way has its ready bit held low until the barrier commits. Each barrier keeps its dependents as a bitmask over slots, so a commit can release all of them in one cycle.

Barriers form a backward chain. A newly dispatched barrier becomes the current one and remembers the barrier it replaced as its single source. A commit is taken only while no store is waiting to write back. A committing barrier clears the current pointer only if it is still the youngest barrier. A squash with sequence number N removes every slot younger than N. The tracker then spends one cycle per removed barrier walking the pointer back along the chain, to the youngest survivor or to none, and reports itself busy while it does so.

An issue-eligibility vector combines the memory-ready state with per-slot register-ready and speculation-allowed inputs. This lets a scheduler pick candidates directly.

Top module: `mem_barrier_tracker`

## Requirements
- R1: After reset every bit of `memReady` and `issueOk` is 0, `curValid` is 0 and `busy` is 0.
- R2: A dispatch taken while no current barrier exists leaves its slot's `memReady` bit at 1 from the next cycle.
- R3: A memory reference or barrier dispatched while a current barrier exists has its `memReady` bit at 0 until that barrier commits. A dispatch that is neither of these is ready at once.
- R4: A dispatched barrier becomes the current barrier on the next cycle: `curValid`=1 and `curSlot` equals its slot.
- R5: A commit request made while `storePending`=1 has no effect: the pointer and all ready bits stay unchanged.
- R6: A taken commit sets `memReady` on the next cycle for every slot linked to the committing barrier, frees the barrier's slot (its bit reads 0), and clears its dependent mask.
- R7: Committing a barrier that is not the current one leaves `curValid`/`curSlot` unchanged. A barrier that was linked to it becomes memory-ready.
- R8: A squash with sequence number N clears on the next cycle every slot whose sequence number is greater than N and raises `busy`. Dependent bits of removed slots are dropped from the masks of surviving barriers.
- R9: While busy, the pointer moves one link back per cycle as long as the current barrier's sequence number is greater than N. It ends on the youngest surviving barrier, or with `curValid`=0. `busy` is high for (removed barriers + 1) cycles.
- R10: `issueOk[i]` = slot valid, memory-ready, `regReady[i]`=1, `specOk[i]`=1, and slot i not a barrier.
- R11: If a commit of the current barrier and a dispatch happen in the same cycle, the dispatched instruction is not linked to it and `curValid` goes to 0, unless the dispatched instruction is itself a barrier.
- R12: Dispatch and commit requests presented while `busy`=1, or in the cycle of a squash, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch an instruction this cycle |
| dispSlot | input | SLOTW | Slot receiving the instruction |
| dispIsBarrier | input | 1 | Dispatched instruction is a barrier |
| dispIsMem | input | 1 | Dispatched instruction is a memory reference |
| dispSeq | input | SEQW | Sequence number of the dispatched instruction |
| commitValid | input | 1 | Barrier in `commitSlot` requests commit |
| commitSlot | input | SLOTW | Slot of the committing barrier |
| storePending | input | 1 | Stores still waiting to write back |
| squashValid | input | 1 | Squash everything younger than `squashSeq` |
| squashSeq | input | SEQW | Squash boundary sequence number |
| regReady | input | NSLOT | Per-slot register operands ready |
| specOk | input | NSLOT | Per-slot may issue speculatively |
| memReady | output | NSLOT | Per-slot memory-dependency ready (0 for empty slots) |
| issueOk | output | NSLOT | Per-slot issue eligible |
| curValid | output | 1 | A current barrier exists |
| curSlot | output | SLOTW | Slot of the current barrier |
| busy | output | 1 | Squash unwind in progress |

## Verification
The properties assume well-formed stimulus. Dispatches target empty slots. A commit names a valid barrier that heads the program order, so its own source has already committed. Sequence numbers rise with program order and do not wrap. No squash arrives while `busy` is high. The bench keeps to these rules: it resets between scenarios, gives increasing sequence numbers, and commits barriers oldest first. It also waits for `busy` to fall before making a new legal request, and sends requests during busy cycles only to check that they are ignored.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef struct packed {
    logic doDispatch;
    logic doCommit;
    logic doSquash;
    logic doStep;
  } mbtStrobes_t;

  typedef enum logic {ST_IDLE, ST_UNWIND} mbtState_t;
endpackage

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dispValid,
  input  logic        commitValid,
  input  logic        storePending,
  input  logic        squashValid,
  input  logic        curYounger,
  output mbtStrobes_t strb,
  output logic        busy
);
  mbtState_t state, stateNext;

  always_comb begin
    strb       = '0;
    stateNext  = state;
    if (state == ST_IDLE) begin
      strb.doSquash   = squashValid;
      strb.doDispatch = dispValid && !squashValid;
      strb.doCommit   = commitValid && !storePending && !squashValid;
      if (squashValid) stateNext = ST_UNWIND;
    end else begin
      strb.doStep = curYounger;
      if (!curYounger) stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_UNWIND);
endmodule

// File: rtl/mbt_data.sv
module mbt_data
  import mbt_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int SEQW  = 16,
  localparam int SLOTW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbtStrobes_t      strb,
  input  logic [SLOTW-1:0] dispSlot,
  input  logic             dispIsBarrier,
  input  logic             dispIsMem,
  input  logic [SEQW-1:0]  dispSeq,
  input  logic [SLOTW-1:0] commitSlot,
  input  logic [SEQW-1:0]  squashSeq,
  input  logic [NSLOT-1:0] regReady,
  input  logic [NSLOT-1:0] specOk,
  output logic [NSLOT-1:0] memReady,
  output logic [NSLOT-1:0] issueOk,
  output logic             curValid,
  output logic [SLOTW-1:0] curSlot,
  output logic             curYounger
);
  logic [NSLOT-1:0] slotValid, slotBar, slotRdy, srcValid;
  logic [SEQW-1:0]  slotSeq [NSLOT];
  logic [NSLOT-1:0] depMask [NSLOT];
  logic [SLOTW-1:0] srcSlot [NSLOT];
  logic [SEQW-1:0]  squashSeqQ;

  logic             commitClearsCur, linkNew;
  logic [NSLOT-1:0] releaseMask, killMask;

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      killMask[i] = slotValid[i] && (slotSeq[i] > squashSeq);
  end

  assign curYounger      = curValid && (slotSeq[curSlot] > squashSeqQ);
  assign commitClearsCur = strb.doCommit && curValid && (curSlot == commitSlot);
  assign linkNew         = strb.doDispatch && (dispIsMem || dispIsBarrier) &&
                           curValid && !commitClearsCur;
  assign releaseMask     = strb.doCommit ? depMask[commitSlot] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid  <= '0;
      slotBar    <= '0;
      slotRdy    <= '0;
      srcValid   <= '0;
      curValid   <= 1'b0;
      curSlot    <= '0;
      squashSeqQ <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        slotSeq[i] <= '0;
        depMask[i] <= '0;
        srcSlot[i] <= '0;
      end
    end else begin
      if (strb.doSquash) begin
        squashSeqQ <= squashSeq;
        slotValid  <= slotValid & ~killMask;
        for (int i = 0; i < NSLOT; i++)
          depMask[i] <= depMask[i] & ~killMask;
      end
      if (strb.doStep) begin
        depMask[curSlot] <= '0;
        curValid         <= srcValid[curSlot];
        curSlot          <= srcSlot[curSlot];
      end
      if (strb.doCommit) begin
        slotValid[commitSlot] <= 1'b0;
        depMask[commitSlot]   <= '0;
        slotRdy               <= slotRdy | releaseMask;
        srcValid              <= srcValid & ~releaseMask;
        if (commitClearsCur) curValid <= 1'b0;
      end
      if (strb.doDispatch) begin
        slotValid[dispSlot] <= 1'b1;
        slotBar[dispSlot]   <= dispIsBarrier;
        slotSeq[dispSlot]   <= dispSeq;
        slotRdy[dispSlot]   <= !linkNew;
        depMask[dispSlot]   <= '0;
        srcValid[dispSlot]  <= linkNew && dispIsBarrier;
        srcSlot[dispSlot]   <= curSlot;
        if (linkNew) depMask[curSlot][dispSlot] <= 1'b1;
        if (dispIsBarrier) begin
          curValid <= 1'b1;
          curSlot  <= dispSlot;
        end
      end
    end
  end

  assign memReady = slotValid & slotRdy;
  assign issueOk  = memReady & regReady & specOk & ~slotBar;
endmodule

// File: rtl/mem_barrier_tracker.sv
module mem_barrier_tracker
  import mbt_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int SEQW  = 16,
  localparam int SLOTW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [SLOTW-1:0] dispSlot,
  input  logic             dispIsBarrier,
  input  logic             dispIsMem,
  input  logic [SEQW-1:0]  dispSeq,
  input  logic             commitValid,
  input  logic [SLOTW-1:0] commitSlot,
  input  logic             storePending,
  input  logic             squashValid,
  input  logic [SEQW-1:0]  squashSeq,
  input  logic [NSLOT-1:0] regReady,
  input  logic [NSLOT-1:0] specOk,
  output logic [NSLOT-1:0] memReady,
  output logic [NSLOT-1:0] issueOk,
  output logic             curValid,
  output logic [SLOTW-1:0] curSlot,
  output logic             busy
);
  mbtStrobes_t strb;
  logic        curYounger;

  mbt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .commitValid(commitValid),
    .storePending(storePending), .squashValid(squashValid),
    .curYounger(curYounger), .strb(strb), .busy(busy)
  );

  mbt_data #(.NSLOT(NSLOT), .SEQW(SEQW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dispSlot(dispSlot),
    .dispIsBarrier(dispIsBarrier), .dispIsMem(dispIsMem), .dispSeq(dispSeq),
    .commitSlot(commitSlot), .squashSeq(squashSeq), .regReady(regReady),
    .specOk(specOk), .memReady(memReady), .issueOk(issueOk),
    .curValid(curValid), .curSlot(curSlot), .curYounger(curYounger)
  );
endmodule

// File: rtl/mbt_checker.sv
module mbt_checker #(
  parameter int NSLOT = 8,
  parameter int SEQW  = 16,
  localparam int SLOTW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic [SLOTW-1:0] dispSlot,
  input logic             dispIsBarrier,
  input logic             dispIsMem,
  input logic             commitValid,
  input logic [SLOTW-1:0] commitSlot,
  input logic             storePending,
  input logic             squashValid,
  input logic [NSLOT-1:0] memReady,
  input logic [NSLOT-1:0] issueOk,
  input logic             curValid,
  input logic [SLOTW-1:0] curSlot,
  input logic             busy
);
  AST_FREE_DISPATCH_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !squashValid && dispValid && !curValid) |=> memReady[$past(dispSlot)]); // R2

  AST_LINKED_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !squashValid && dispValid && (dispIsMem || dispIsBarrier) && curValid &&
     !(commitValid && !storePending && commitSlot == curSlot))
    |=> !memReady[$past(dispSlot)]); // R3

  AST_BARRIER_BECOMES_CURRENT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !squashValid && dispValid && dispIsBarrier)
    |=> (curValid && curSlot == $past(dispSlot))); // R4

  AST_STORE_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !squashValid && !dispValid && commitValid && storePending)
    |=> ($stable(curValid) && $stable(curSlot) && $stable(memReady))); // R5

  AST_SQUASH_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && squashValid) |=> busy); // R8

  AST_UNWIND_ENDS_AT_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !curValid) |=> !busy); // R9

  AST_ISSUE_NEEDS_MEMREADY: assert property (@(posedge clk) disable iff (!rstN)
    ((issueOk & ~memReady) == '0)); // R10
endmodule

bind mem_barrier_tracker mbt_checker #(.NSLOT(NSLOT), .SEQW(SEQW)) uChk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispSlot(dispSlot),
  .dispIsBarrier(dispIsBarrier), .dispIsMem(dispIsMem), .commitValid(commitValid),
  .commitSlot(commitSlot), .storePending(storePending), .squashValid(squashValid),
  .memReady(memReady), .issueOk(issueOk), .curValid(curValid), .curSlot(curSlot),
  .busy(busy)
);

// File: tb/mem_barrier_tracker_test.sv
module mem_barrier_tracker_test;
  localparam int NSLOT = 4;
  localparam int SEQW  = 8;
  localparam int SLOTW = 2;

  logic             clk = 1'b0;
  logic             rstN;
  logic             dispValid, dispIsBarrier, dispIsMem;
  logic [SLOTW-1:0] dispSlot, commitSlot;
  logic [SEQW-1:0]  dispSeq, squashSeq;
  logic             commitValid, storePending, squashValid;
  logic [NSLOT-1:0] regReady, specOk, memReady, issueOk;
  logic             curValid, busy;
  logic [SLOTW-1:0] curSlot;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mem_barrier_tracker #(.NSLOT(NSLOT), .SEQW(SEQW)) uut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispSlot(dispSlot),
    .dispIsBarrier(dispIsBarrier), .dispIsMem(dispIsMem), .dispSeq(dispSeq),
    .commitValid(commitValid), .commitSlot(commitSlot), .storePending(storePending),
    .squashValid(squashValid), .squashSeq(squashSeq), .regReady(regReady),
    .specOk(specOk), .memReady(memReady), .issueOk(issueOk), .curValid(curValid),
    .curSlot(curSlot), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    dispValid = 0; dispIsBarrier = 0; dispIsMem = 0; dispSlot = 0; dispSeq = 0;
    commitValid = 0; commitSlot = 0; storePending = 0; squashValid = 0; squashSeq = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clearIn();
  endtask

  task automatic doReset();
    clearIn();
    regReady = '1; specOk = '1;
    rstN = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
  endtask

  task automatic disp(input int slot, input bit bar, input bit mem, input int seq);
    dispValid = 1; dispSlot = slot[SLOTW-1:0]; dispIsBarrier = bar;
    dispIsMem = mem; dispSeq = seq[SEQW-1:0];
    tick();
  endtask

  task automatic commitReq(input int slot, input bit pend);
    commitValid = 1; commitSlot = slot[SLOTW-1:0]; storePending = pend;
    tick();
  endtask

  // chain: s0 barrier seq10, s1 mem seq11, s2 barrier seq12, s3 mem seq13
  task automatic buildChain();
    disp(0, 1, 0, 10);
    disp(1, 0, 1, 11);
    disp(2, 1, 0, 12);
    disp(3, 0, 1, 13);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    // R1
    check(memReady == 0 && issueOk == 0, "R1 ready bits", memReady, 0);
    check(!curValid && !busy, "R1 pointer/busy", {curValid, busy}, 0);

    // R2 R3 R4 on the chain
    buildChain();
    check(memReady == 4'b0001, "R2/R3 chain ready", memReady, 1);
    check(curValid && curSlot == 2, "R4 current slot", curSlot, 2);

    // R5: commit of slot 0 with store pending
    commitReq(0, 1);
    check(memReady == 4'b0001 && curValid && curSlot == 2, "R5 blocked commit", memReady, 1);

    // R7 + R6: commit older barrier slot0; pointer stays at 2, s1 and s2 ready, s0 freed
    commitReq(0, 0);
    check(memReady == 4'b0110, "R6 release", memReady, 6);
    check(curValid && curSlot == 2, "R7 pointer kept", curSlot, 2);

    // R11: commit current barrier (2) while dispatching mem into slot0
    commitValid = 1; commitSlot = 2;
    disp(0, 0, 1, 20);
    check(memReady == 4'b1011, "R11 unlinked dispatch", memReady, 11);
    check(!curValid, "R11 pointer cleared", curValid, 0);

    // R3: non-mem dispatch with current barrier is ready
    doReset();
    disp(0, 1, 0, 1);
    disp(1, 0, 0, 2);
    check(memReady == 4'b0011, "R3 plain op ready", memReady, 3);

    // R10 sweep: s0 plain ready, s1 mem ready, s2 barrier ready, s3 mem linked
    doReset();
    disp(0, 0, 0, 1);
    disp(1, 0, 1, 2);
    disp(2, 1, 0, 3);
    disp(3, 0, 1, 4);
    for (int rr = 0; rr < 16; rr++)
      for (int so = 0; so < 16; so++) begin
        regReady = rr[3:0]; specOk = so[3:0];
        #1;
        check(issueOk == (4'b0011 & rr[3:0] & so[3:0]), "R10 issue gating",
              issueOk, 4'b0011 & rr[3:0] & so[3:0]);
      end

    // R8 R9 R12: squash sweep over boundary N
    for (int n = 9; n <= 13; n++) begin
      int killedBars, busyCycles, expCur, expReady;
      bit expCv;
      doReset();
      buildChain();
      killedBars = (10 > n) + (12 > n);
      expCv = (n >= 10);
      expCur = (n >= 12) ? 2 : 0;
      expReady = (n >= 10) ? 1 : 0;
      squashValid = 1; squashSeq = n[SEQW-1:0];
      commitValid = 1; commitSlot = 0;  // R12: ignored in squash cycle
      tick();
      check(busy, "R8 busy after squash", busy, 1);
      busyCycles = 0;
      while (busy && busyCycles < 10) begin
        busyCycles++;
        dispValid = 1; dispSlot = 3; dispIsMem = 1; dispSeq = 50;  // R12: ignored
        commitValid = 1; commitSlot = 0;
        tick();
      end
      check(busyCycles == killedBars + 1, "R9 unwind length", busyCycles, killedBars + 1);
      check(curValid == expCv && (!expCv || curSlot == expCur), "R9 pointer",
            curSlot, expCur);
      check(memReady == expReady[3:0], "R8/R12 survivors", memReady, expReady);
      if (n == 11) begin
        // s2,s3 dropped from s0 mask: commit releases only s1
        commitReq(0, 0);
        check(memReady == 4'b0010, "R8 mask cleaned", memReady, 2);
        check(!curValid, "R6 pointer after commit", curValid, 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule